// File: doc/BRIEF.md
# Serial Receive Path with Status-Tagged FIFO

This block is the receive side of a register-mapped serial port. An oversampling receiver turns asynchronous frames on a single line into characters. Each character goes into a 16-deep queue, together with flags that describe how the frame arrived. Software reads and controls the block through a small word-wide read/write port with four registers. Reading the data register takes the oldest character off the queue.

Three conditions are tracked as interrupt status, and each has its own enable:

- a character that arrived while the queue was full;
- a fill level that has reached a programmable mark;
- data left unread for a programmable number of character times.

The overrun condition is sticky. Only the queue-flush bit in the control register clears it, and that flush also discards all stored characters.

Register map: address 0 is control, 1 is the bit-rate divisor, 2 is interrupt mask and status, and 3 is received data.

The control word has these fields:

| Bits | Field |
|------|-------|
| 0 | receive enable |
| 1 | rate generator enable |
| 2 | queue flush, write 1, reads 0 |
| 3 | parity enable |
| 4 | odd parity |
| 11:8 | timeout in character times |
| 20:16 | fill mark, reset value 8 |

The divisor D gives one sample tick every D+1 clocks. There are 16 ticks per bit, and a character time is 160 ticks.

Top module: `uartrx_top`

## Requirements
- R1: Characters leave the queue in arrival order, up to 16 held. A read of address 3 returns the byte in bits 7:0 and valid=1 in bit 11, then removes it. A read of address 3 while the queue is empty returns all zeros.
- R2: With parity enabled (control bit 3), bit 9 of a data word is set when the received parity bit disagrees with the selected sense. The sense is even when control bit 4 is 0 and odd when it is 1. With parity disabled, bit 9 is 0.
- R3: Bit 10 (framing) is set when the stop bit is sampled low. Bit 8 (break) is set when the data bits, any parity bit and the stop bit are all low.
- R4: Bit 11 of address 2 is 1 exactly when at least one character is waiting.
- R5: A character that completes while 16 are held is dropped and sets overrun status (address 2 bit 8). The held characters stay unchanged.
- R6: Overrun status survives reads of the data register and clears only when control bit 2 is written as 1. That write also empties the queue.
- R7: Level status (address 2 bit 9) is 1 while the fill mark is non-zero and the fill level is at or above it.
- R8: With a timeout field N other than 0, timeout status (address 2 bit 10) sets after N character times with no push and no pop while data waits. It clears when the queue becomes empty. N=0 disables it.
- R9: The line is ignored unless control bits 0 and 1 are both 1.
- R10: The interrupt output is 1 exactly when some status bit in address 2 bits 10:8 has its mask bit set. The mask bits are address 2 bits 2:0, in the same order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial input, idle high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of address 3 pops |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while reg_rd is high |
| irq | output | 1 | Combined masked interrupt |

## Verification
The hardest state to reach is the overrun edge. It needs a full queue, one more complete frame arriving, and then proof that the 16 stored characters are untouched and that the status outlives every pop. The bench streams seventeen numbered frames and checks that overrun stays clear after the sixteenth and is set after the seventeenth. It then drains and compares all sixteen in order, confirms the queue is empty, and flushes last to watch the status drop. The timeout is checked by sampling just before and just after one character time measured from the last push.

// File: rtl/uartrx_pkg.sv
package uartrx_pkg;
  // One queue entry; bit layout is the software-visible data word.
  typedef struct packed {
    logic       valid;
    logic       frame_err;
    logic       par_err;
    logic       brk;
    logic [7:0] data;
  } rx_entry_t;

  localparam int unsigned ENTRY_W    = $bits(rx_entry_t);
  localparam int unsigned OVS        = 16;
  localparam int unsigned CHAR_TICKS = OVS * 10;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD
  } rx_state_t;
endpackage

// File: rtl/uartrx_deser.sv
module uartrx_deser
  import uartrx_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             baud_en,
  input  logic [DIV_W-1:0] div,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             rx_line,
  output logic             tick,
  output logic             push,
  output rx_entry_t        entry
);
  logic [1:0]       sync_q;
  logic             rx_s;
  logic [DIV_W-1:0] dcnt_q, dcnt_d;
  rx_state_t        st_q, st_d;
  logic [3:0]       sub_q, sub_d;
  logic [2:0]       idx_q, idx_d;
  logic [7:0]       shf_q, shf_d;
  logic             pbit_q, pbit_d;
  logic             push_q, push_d;
  rx_entry_t        ent_q, ent_d;
  logic             run;

  assign rx_s = sync_q[1];
  assign run  = rx_en & baud_en;
  assign tick = baud_en && (dcnt_q == div);

  always_comb begin
    dcnt_d = !baud_en ? '0 : (tick ? '0 : dcnt_q + 1'b1);
    st_d   = st_q;
    sub_d  = sub_q;
    idx_d  = idx_q;
    shf_d  = shf_q;
    pbit_d = pbit_q;
    push_d = 1'b0;
    ent_d  = ent_q;
    if (!run) begin
      st_d = RX_IDLE;
    end else begin
      case (st_q)
        RX_IDLE: if (!rx_s) begin st_d = RX_START; sub_d = '0; end
        RX_START: if (tick) begin
          if (sub_q == 4'd7) begin
            sub_d  = '0;
            idx_d  = '0;
            pbit_d = 1'b0;
            st_d   = rx_s ? RX_IDLE : RX_DATA;
          end else sub_d = sub_q + 1'b1;
        end
        RX_DATA: if (tick) begin
          sub_d = sub_q + 1'b1;
          if (sub_q == 4'd15) begin
            shf_d = {rx_s, shf_q[7:1]};
            idx_d = idx_q + 1'b1;
            if (idx_q == 3'd7) st_d = par_en ? RX_PAR : RX_STOP;
          end
        end
        RX_PAR: if (tick) begin
          sub_d = sub_q + 1'b1;
          if (sub_q == 4'd15) begin pbit_d = rx_s; st_d = RX_STOP; end
        end
        RX_STOP: if (tick) begin
          sub_d = sub_q + 1'b1;
          if (sub_q == 4'd15) begin
            push_d          = 1'b1;
            ent_d.valid     = 1'b1;
            ent_d.data      = shf_q;
            ent_d.frame_err = !rx_s;
            ent_d.brk       = !rx_s && (shf_q == 8'h00) && !(par_en && pbit_q);
            ent_d.par_err   = par_en && ((^shf_q ^ pbit_q) != par_odd);
            st_d            = rx_s ? RX_IDLE : RX_HOLD;
          end
        end
        RX_HOLD: if (rx_s) st_d = RX_IDLE;
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      dcnt_q <= '0;
      st_q   <= RX_IDLE;
      sub_q  <= '0;
      idx_q  <= '0;
      shf_q  <= '0;
      pbit_q <= 1'b0;
      push_q <= 1'b0;
      ent_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], rx_line};
      dcnt_q <= dcnt_d;
      st_q   <= st_d;
      sub_q  <= sub_d;
      idx_q  <= idx_d;
      shf_q  <= shf_d;
      pbit_q <= pbit_d;
      push_q <= push_d;
      ent_q  <= ent_d;
    end
  end

  assign push  = push_q;
  assign entry = ent_q;

  // R9: a disabled receiver never produces a character
  a_r9_off_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !push_q);
endmodule

// File: rtl/uartrx_fifo.sv
module uartrx_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 12,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [LVL_W-1:0] level,
  output logic             empty,
  output logic             full,
  output logic             drop
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             do_push, do_pop;

  assign empty   = (lvl_q == '0);
  assign full    = (lvl_q == LVL_W'(DEPTH));
  assign do_push = push && !full && !clear;
  assign do_pop  = pop && !empty && !clear;
  assign drop    = push && full && !clear;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    lvl_d = lvl_q;
    if (clear) begin
      wp_d  = '0;
      rp_d  = '0;
      lvl_d = '0;
    end else begin
      if (do_push) wp_d = (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_d = (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      if (do_push && !do_pop)      lvl_d = lvl_q + 1'b1;
      else if (do_pop && !do_push) lvl_d = lvl_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= din;
  end

  assign dout  = mem_q[rp_q];
  assign level = lvl_q;

  // R5: fill level never passes the depth
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LVL_W'(DEPTH));
  // R5: a full queue stays full until a pop or flush
  a_r5_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    full && !pop && !clear |=> full);
endmodule

// File: rtl/uartrx_irq.sv
module uartrx_irq #(
  parameter int unsigned LVL_W      = 5,
  parameter int unsigned TMO_W      = 4,
  parameter int unsigned CHAR_TICKS = 160,
  localparam int unsigned TC_W      = $clog2(CHAR_TICKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic             pop,
  input  logic             drop,
  input  logic             tick,
  input  logic             empty,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] mark,
  input  logic [TMO_W-1:0] tmo_chars,
  input  logic [2:0]       mask,
  output logic [2:0]       stat,
  output logic             irq
);
  logic             ovr_q, ovr_d, tmo_q, tmo_d, thr;
  logic [TC_W-1:0]  tc_q, tc_d;
  logic [TMO_W-1:0] cc_q, cc_d;
  logic             restart, char_end;

  assign thr      = (mark != '0) && (level >= mark);
  assign restart  = push || pop || clear || empty;
  assign char_end = tick && (tc_q == TC_W'(CHAR_TICKS - 1));

  always_comb begin
    ovr_d = clear ? 1'b0 : (ovr_q | drop);
    tc_d  = tc_q;
    cc_d  = cc_q;
    if (restart) begin
      tc_d = '0;
      cc_d = '0;
    end else if (tick) begin
      tc_d = char_end ? '0 : tc_q + 1'b1;
      if (char_end && cc_q != '1) cc_d = cc_q + 1'b1;
    end
    if (empty || clear) tmo_d = 1'b0;
    else if (tmo_chars != '0 && cc_q == tmo_chars) tmo_d = 1'b1;
    else tmo_d = tmo_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      tmo_q <= 1'b0;
      tc_q  <= '0;
      cc_q  <= '0;
    end else begin
      ovr_q <= ovr_d;
      tmo_q <= tmo_d;
      tc_q  <= tc_d;
      cc_q  <= cc_d;
    end
  end

  assign stat = {tmo_q, thr, ovr_q};
  assign irq  = |(stat & mask);

  // R6: overrun holds until a flush
  a_r6_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q && !clear |=> ovr_q);
  // R8: timeout status drops once the queue is empty
  a_r8_tmo_clear_empty: assert property (@(posedge clk) disable iff (!rst_n)
    empty |=> !tmo_q);
endmodule

// File: rtl/uartrx_top.sv
module uartrx_top
  import uartrx_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DIV_W = 16,
  parameter int unsigned TMO_W = 4,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_line,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  localparam logic [1:0] A_CTRL = 2'd0, A_BAUD = 2'd1, A_IRQ = 2'd2, A_DATA = 2'd3;

  logic rst_meta_q, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_q, rst_meta_q} <= 2'b00;
    else        {rst_q, rst_meta_q} <= {rst_meta_q, 1'b1};
  end

  logic             rxen_q, rxen_d, ben_q, ben_d, pen_q, pen_d, podd_q, podd_d;
  logic             clr_q, clr_d;
  logic [TMO_W-1:0] tmo_q, tmo_d;
  logic [LVL_W-1:0] mark_q, mark_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [2:0]       mask_q, mask_d;

  always_comb begin
    rxen_d = rxen_q; ben_d = ben_q; pen_d = pen_q; podd_d = podd_q;
    tmo_d = tmo_q; mark_d = mark_q; div_d = div_q; mask_d = mask_q;
    clr_d = 1'b0;
    if (reg_wr) begin
      case (reg_addr)
        A_CTRL: begin
          rxen_d = reg_wdata[0];
          ben_d  = reg_wdata[1];
          clr_d  = reg_wdata[2];
          pen_d  = reg_wdata[3];
          podd_d = reg_wdata[4];
          tmo_d  = reg_wdata[8 +: TMO_W];
          mark_d = reg_wdata[16 +: LVL_W];
        end
        A_BAUD:  div_d  = reg_wdata[DIV_W-1:0];
        A_IRQ:   mask_d = reg_wdata[2:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rxen_q <= 1'b0; ben_q <= 1'b0; pen_q <= 1'b0; podd_q <= 1'b0;
      clr_q  <= 1'b0;
      tmo_q  <= '0;
      mark_q <= LVL_W'(DEPTH / 2);
      div_q  <= '0;
      mask_q <= '0;
    end else begin
      rxen_q <= rxen_d; ben_q <= ben_d; pen_q <= pen_d; podd_q <= podd_d;
      clr_q  <= clr_d;
      tmo_q  <= tmo_d;
      mark_q <= mark_d;
      div_q  <= div_d;
      mask_q <= mask_d;
    end
  end

  logic             tick, push, pop, empty, full, drop;
  rx_entry_t        entry, head;
  logic [LVL_W-1:0] level;
  logic [2:0]       stat;

  uartrx_deser #(.DIV_W(DIV_W)) u_deser (
    .clk(clk), .rst_n(rst_q), .rx_en(rxen_q), .baud_en(ben_q), .div(div_q),
    .par_en(pen_q), .par_odd(podd_q), .rx_line(rx_line),
    .tick(tick), .push(push), .entry(entry)
  );

  assign pop = reg_rd && (reg_addr == A_DATA) && !empty;

  uartrx_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
    .clk(clk), .rst_n(rst_q), .clear(clr_q), .push(push), .din(entry),
    .pop(pop), .dout(head), .level(level), .empty(empty), .full(full),
    .drop(drop)
  );

  uartrx_irq #(.LVL_W(LVL_W), .TMO_W(TMO_W), .CHAR_TICKS(CHAR_TICKS)) u_irq (
    .clk(clk), .rst_n(rst_q), .clear(clr_q), .push(push && !full),
    .pop(pop), .drop(drop), .tick(tick), .empty(empty), .level(level),
    .mark(mark_q), .tmo_chars(tmo_q), .mask(mask_q), .stat(stat), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        A_CTRL: begin
          reg_rdata[0]              = rxen_q;
          reg_rdata[1]              = ben_q;
          reg_rdata[3]              = pen_q;
          reg_rdata[4]              = podd_q;
          reg_rdata[8 +: TMO_W]     = tmo_q;
          reg_rdata[16 +: LVL_W]    = mark_q;
        end
        A_BAUD: reg_rdata[DIV_W-1:0] = div_q;
        A_IRQ: begin
          reg_rdata[2:0]  = mask_q;
          reg_rdata[10:8] = stat;
          reg_rdata[11]   = !empty;
        end
        default: if (!empty) reg_rdata[ENTRY_W-1:0] = head;
      endcase
    end
  end

  // R1: a read of an empty queue never reports a valid character
  a_r1_empty_read: assert property (@(posedge clk) disable iff (!rst_q)
    reg_rd && reg_addr == A_DATA && empty |-> reg_rdata == 32'h0);
endmodule

// File: tb/sim_uartrx_top.sv
module sim_uartrx_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_line = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  int          n_chk = 0, n_err = 0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  uartrx_top u0 (.clk(clk), .rst_n(rst_n), .rx_line(rx_line), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq));

  // fields: [23:16] byte, [15:14] parity mode 0 none/1 even/2 odd,
  // [13] flip parity, [12] stop low, [11:0] expected data word
  localparam logic [23:0] VEC [7] = '{
    {8'h55, 2'd0, 1'b0, 1'b0, 12'h855},
    {8'hA3, 2'd1, 1'b0, 1'b0, 12'h8A3},
    {8'hA3, 2'd1, 1'b1, 1'b0, 12'hAA3},
    {8'h0F, 2'd2, 1'b0, 1'b0, 12'h80F},
    {8'h3C, 2'd0, 1'b0, 1'b1, 12'hC3C},
    {8'h00, 2'd0, 1'b0, 1'b1, 12'hD00},
    {8'h00, 2'd2, 1'b0, 1'b0, 12'h800}
  };

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    wclk(1);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #2 d = reg_rdata;
    wclk(1);
    reg_rd = 1'b0;
  endtask

  task automatic ctrl(input logic rxen, input logic ben, input logic pen,
                      input logic odd, input logic clr, input logic [3:0] tmo,
                      input logic [4:0] mark);
    wreg(2'd0, {11'b0, mark, 4'b0, tmo, 3'b0, odd, pen, clr, ben, rxen});
  endtask

  task automatic send(input logic [7:0] d, input logic [1:0] mode,
                      input logic flip, input logic stop_low);
    logic pb;
    pb = ((mode == 2'd2) ? ~^d : ^d) ^ flip;
    rx_line = 1'b0; wclk(16);
    for (int i = 0; i < 8; i++) begin rx_line = d[i]; wclk(16); end
    if (mode != 2'd0) begin rx_line = pb; wclk(16); end
    rx_line = !stop_low; wclk(16);
    rx_line = 1'b1; wclk(16);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    wclk(3);
    rst_n = 1'b1;
    wclk(4);
    // reset state
    rreg(2'd0, v); check("R7 reset mark", v, 32'h0008_0000);
    rreg(2'd2, v); check("R4 reset status", v, 32'h0);
    rreg(2'd3, v); check("R1 reset empty read", v, 32'h0);
    check("R10 reset irq", {31'b0, irq}, 32'h0);

    // vector table: format and flags
    for (int k = 0; k < 7; k++) begin
      ctrl(1, 1, VEC[k][15:14] != 2'd0, VEC[k][15:14] == 2'd2, 0, 4'd0, 5'd8);
      send(VEC[k][23:16], VEC[k][15:14], VEC[k][13], VEC[k][12]);
      rreg(2'd2, v); check("R4 not-empty", {31'b0, v[11]}, 32'h1);
      rreg(2'd3, v); check("R1 R2 R3 data word", v, {20'b0, VEC[k][11:0]});
      rreg(2'd3, v); check("R1 empty after pop", v, 32'h0);
    end

    // R9: either enable cleared ignores the line
    ctrl(0, 1, 0, 0, 0, 4'd0, 5'd8);
    send(8'h5A, 2'd0, 0, 0);
    rreg(2'd2, v); check("R9 rx disabled", {31'b0, v[11]}, 32'h0);
    ctrl(1, 0, 0, 0, 0, 4'd0, 5'd8);
    send(8'h5A, 2'd0, 0, 0);
    rreg(2'd2, v); check("R9 rate gen disabled", {31'b0, v[11]}, 32'h0);

    // R7: level status at mark 3
    ctrl(1, 1, 0, 0, 0, 4'd0, 5'd3);
    send(8'h01, 2'd0, 0, 0); send(8'h02, 2'd0, 0, 0);
    rreg(2'd2, v); check("R7 below mark", {31'b0, v[9]}, 32'h0);
    send(8'h03, 2'd0, 0, 0);
    rreg(2'd2, v); check("R7 at mark", {31'b0, v[9]}, 32'h1);
    rreg(2'd3, v);
    rreg(2'd2, v); check("R7 after pop", {31'b0, v[9]}, 32'h0);
    ctrl(1, 1, 0, 0, 1, 4'd0, 5'd8);
    wclk(3);
    rreg(2'd2, v); check("R6 flush empties", {31'b0, v[11]}, 32'h0);

    // R8 and R10: timeout of one character time
    ctrl(1, 1, 0, 0, 0, 4'd1, 5'd8);
    send(8'h77, 2'd0, 0, 0);
    wclk(100);
    rreg(2'd2, v); check("R8 before timeout", {31'b0, v[10]}, 32'h0);
    wclk(40);
    rreg(2'd2, v); check("R8 after timeout", {31'b0, v[10]}, 32'h1);
    wreg(2'd2, 32'h4); wclk(1);
    check("R10 timeout masked in", {31'b0, irq}, 32'h1);
    wreg(2'd2, 32'h3); wclk(1);
    check("R10 timeout masked out", {31'b0, irq}, 32'h0);
    rreg(2'd3, v); wclk(2);
    rreg(2'd2, v); check("R8 clear on empty", {31'b0, v[10]}, 32'h0);
    ctrl(1, 1, 0, 0, 0, 4'd0, 5'd8);
    send(8'h66, 2'd0, 0, 0);
    wclk(400);
    rreg(2'd2, v); check("R8 disabled", {31'b0, v[10]}, 32'h0);
    rreg(2'd3, v);

    // R5 and R6: overrun
    wreg(2'd2, 32'h1);
    for (int i = 1; i <= 16; i++) send(8'(i), 2'd0, 0, 0);
    rreg(2'd2, v); check("R5 full no overrun", {31'b0, v[8]}, 32'h0);
    send(8'h11, 2'd0, 0, 0);
    rreg(2'd2, v); check("R5 overrun set", {31'b0, v[8]}, 32'h1);
    check("R10 overrun irq", {31'b0, irq}, 32'h1);
    for (int i = 1; i <= 16; i++) begin
      rreg(2'd3, v); check("R5 stored kept", v, 32'h800 | 32'(i));
    end
    rreg(2'd3, v); check("R5 extra dropped", v, 32'h0);
    rreg(2'd2, v); check("R6 overrun survives pops", {31'b0, v[8]}, 32'h1);
    ctrl(1, 1, 0, 0, 1, 4'd0, 5'd8);
    wclk(3);
    rreg(2'd2, v); check("R6 flush clears overrun", {31'b0, v[8]}, 32'h0);
    check("R10 irq low", {31'b0, irq}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule